// File: doc/BRIEF.md
# Nested Transaction Read/Write Tracker

This block follows, for every line of a small private cache, which nesting levels of a hardware transaction have read or written that line. Each line holds one read flag and one write flag per level, up to `DEPTH` levels (four by default). The core drives begin, commit and abort pulses for nested levels, plus tracked loads and stores that mark the current level only. When a nested level commits, its flags merge into the enclosing level. When a nested level aborts, its flags are dropped and the enclosing levels are left as they were. Committing the outermost level clears every flag in every line.

Snoops from other agents come in on a separate port. A remote write (an invalidating snoop) that lands on a line held in any read or write set of an open level is a conflict. The block then reports the outermost level whose sets hold that line. Only that level and the levels nested inside it have to roll back. Each line also keeps a valid, dirty and exclusive state that the snoop response returns. Lines are addressed directly by their index.

Top module: `nested_rw_tracker`

## Requirements
- R1: After reset the depth is 0, the overflow flag is 0 and no snoop response (`rsp_vld_o`, `viol_o`) is raised.
- R2: A begin pulse raises the depth by one, up to `DEPTH`. A begin at depth `DEPTH` leaves the depth unchanged and sets `ovf_o`. `ovf_o` stays set until the depth returns to 0.
- R3: At depth d ≥ 1, a load marks the read flag of level index d-1 (0 = outermost) for the addressed line, and a store marks its write flag; no other level changes. At depth 0, accesses mark no flag.
- R4: A commit at depth d > 1 ORs the flags of level index d-1 into level index d-2, clears level d-1 and lowers the depth by one.
- R5: An abort at depth d ≥ 1 clears the flags of level index d-1 in every line, keeps all other levels and lowers the depth by one.
- R6: A commit at depth 1 clears every flag of every level in every line and sets the depth to 0.
- R7: An invalidating snoop (`snp_inv_i`=1) to a line with a read or write flag at any level gives `viol_o`=1 in the following cycle. `viol_lvl_o` is the smallest level index holding a flag for that line (0 = outermost).
- R8: A non-invalidating snoop never reports a violation, and neither does an invalidating snoop to a line with no flags set.
- R9: Line state: a load to an invalid line makes it valid, exclusive and clean. A store makes it valid, exclusive and dirty. A non-invalidating snoop clears only exclusive. An invalidating snoop clears all three. The response (`rsp_hit_o`, `rsp_dirty_o`, `rsp_excl_o`) is registered and returns the state seen before that snoop.
- R10: A commit or abort at depth 0 is ignored: the depth stays 0 and no flags change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Open a nested level |
| tx_commit_i | input | 1 | Commit the innermost level |
| tx_abort_i | input | 1 | Abort the innermost level (priority over commit, which has priority over begin) |
| ld_i | input | 1 | Tracked load |
| st_i | input | 1 | Tracked store |
| acc_addr_i | input | ADDR_W | Line index of the access |
| snp_i | input | 1 | Snoop request |
| snp_inv_i | input | 1 | Snoop is a remote write (invalidating) |
| snp_addr_i | input | ADDR_W | Line index of the snoop |
| depth_o | output | DEPTH_W | Current nesting depth |
| ovf_o | output | 1 | Refused begin seen (sticky until depth 0) |
| rsp_vld_o | output | 1 | Snoop response valid |
| viol_o | output | 1 | Conflict detected |
| viol_lvl_o | output | LVL_W | Outermost conflicting level index |
| rsp_hit_o | output | 1 | Snooped line was valid |
| rsp_dirty_o | output | 1 | Snooped line was dirty |
| rsp_excl_o | output | 1 | Snooped line was exclusive |

## Verification
The embedded properties check on every cycle that the depth never goes past its limit and that a refused begin holds the depth and raises overflow. They also check that commits step the depth down and that commands at depth 0 do nothing. No line ever holds a flag at a level that is not open, a violation only follows an invalidating snoop, and its level is always one that was open. Only the bench scenarios can show which level a flag lands in, whether merge and drop move the right flags, and the exact line state returned per snoop. The bench observes these through the violation level and state of later snoops.

// File: rtl/ntx_pkg.sv
package ntx_pkg;

  typedef enum logic [1:0] {
    LCMD_NONE  = 2'd0,
    LCMD_MERGE = 2'd1,
    LCMD_DROP  = 2'd2,
    LCMD_WIPE  = 2'd3
  } lvl_cmd_e;

  typedef struct packed {
    logic vld;
    logic dirty;
    logic excl;
  } line_st_t;

endpackage

// File: rtl/ntx_depth_ctrl.sv
module ntx_depth_ctrl
  import ntx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = 3,
  parameter int LVL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               begin_i,
  input  logic               commit_i,
  input  logic               abort_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic [LVL_W-1:0]   cur_lvl_o,
  output logic               in_txn_o,
  output lvl_cmd_e           cmd_o,
  output logic               ovf_o
);

  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               ovf_q, ovf_d;
  logic               upd_en;
  lvl_cmd_e           cmd;

  assign upd_en = begin_i | commit_i | abort_i;

  always_comb begin
    depth_d = depth_q;
    ovf_d   = ovf_q;
    cmd     = LCMD_NONE;
    if (abort_i && depth_q != '0) begin
      cmd     = LCMD_DROP;
      depth_d = depth_q - DEPTH_W'(1);
    end else if (commit_i && depth_q != '0) begin
      cmd     = (depth_q == DEPTH_W'(1)) ? LCMD_WIPE : LCMD_MERGE;
      depth_d = depth_q - DEPTH_W'(1);
    end else if (begin_i) begin
      if (depth_q == DEPTH_W'(DEPTH)) ovf_d = 1'b1;
      else                            depth_d = depth_q + DEPTH_W'(1);
    end
    if (depth_d == '0) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      ovf_q   <= 1'b0;
    end else if (upd_en) begin
      depth_q <= depth_d;
      ovf_q   <= ovf_d;
    end
  end

  assign depth_o   = depth_q;
  assign cur_lvl_o = LVL_W'(depth_q - DEPTH_W'(1));
  assign in_txn_o  = (depth_q != '0);
  assign cmd_o     = cmd;
  assign ovf_o     = ovf_q;

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(DEPTH)); // R2
  AST_OVF_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (begin_i && !commit_i && !abort_i && depth_q == DEPTH_W'(DEPTH))
      |=> (depth_q == DEPTH_W'(DEPTH) && ovf_q)); // R2
  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !abort_i && depth_q != '0) |=> (depth_q == $past(depth_q) - DEPTH_W'(1))); // R4
  AST_IDLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ((commit_i || abort_i) && !begin_i && depth_q == '0) |=> (depth_q == '0)); // R10

endmodule

// File: rtl/ntx_line.sv
module ntx_line
  import ntx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int DEPTH_W = 3,
  parameter int LVL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_ld_i,
  input  logic               acc_st_i,
  input  logic               in_txn_i,
  input  logic [LVL_W-1:0]   cur_lvl_i,
  input  logic [DEPTH_W-1:0] depth_i,
  input  lvl_cmd_e           cmd_i,
  input  logic               snp_sel_i,
  input  logic               snp_inv_i,
  output logic [DEPTH-1:0]   rw_o,
  output line_st_t           st_o
);

  logic [DEPTH-1:0] rd_q, rd_d, wr_q, wr_d;
  line_st_t         st_q, st_d;
  logic             line_en;
  logic [LVL_W-1:0] par_lvl;

  assign par_lvl = cur_lvl_i - LVL_W'(1);
  assign line_en = acc_ld_i | acc_st_i | snp_sel_i | (cmd_i != LCMD_NONE);

  // flag planes: access first, then the level command
  always_comb begin
    rd_d = rd_q;
    wr_d = wr_q;
    if (in_txn_i && acc_st_i)      wr_d[cur_lvl_i] = 1'b1;
    else if (in_txn_i && acc_ld_i) rd_d[cur_lvl_i] = 1'b1;
    case (cmd_i)
      LCMD_WIPE: begin
        rd_d = '0;
        wr_d = '0;
      end
      LCMD_MERGE: begin
        rd_d[par_lvl]   = rd_d[par_lvl] | rd_d[cur_lvl_i];
        wr_d[par_lvl]   = wr_d[par_lvl] | wr_d[cur_lvl_i];
        rd_d[cur_lvl_i] = 1'b0;
        wr_d[cur_lvl_i] = 1'b0;
      end
      LCMD_DROP: begin
        rd_d[cur_lvl_i] = 1'b0;
        wr_d[cur_lvl_i] = 1'b0;
      end
      default: ;
    endcase
  end

  // line state: snoop first, then the local access
  always_comb begin
    st_d = st_q;
    if (snp_sel_i) begin
      if (snp_inv_i) st_d = '0;
      else           st_d.excl = 1'b0;
    end
    if (acc_st_i) begin
      st_d.vld   = 1'b1;
      st_d.dirty = 1'b1;
      st_d.excl  = 1'b1;
    end else if (acc_ld_i && !st_d.vld) begin
      st_d.vld   = 1'b1;
      st_d.dirty = 1'b0;
      st_d.excl  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      st_q <= '0;
    end else if (line_en) begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      st_q <= st_d;
    end
  end

  assign rw_o = rd_q | wr_q;
  assign st_o = st_q;

  for (genvar lv = 0; lv < DEPTH; lv++) begin : g_lvl_chk
    AST_NO_STALE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (DEPTH_W'(lv) >= depth_i) |-> !(rd_q[lv] | wr_q[lv])); // R5
  end

endmodule

// File: rtl/ntx_snoop_resp.sv
module ntx_snoop_resp
  import ntx_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 4,
  parameter int DEPTH_W   = 3,
  parameter int LVL_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snp_i,
  input  logic               snp_inv_i,
  input  logic [ADDR_W-1:0]  snp_addr_i,
  input  logic [DEPTH-1:0]   rw_all_i [NUM_LINES],
  input  line_st_t           st_all_i [NUM_LINES],
  input  logic [DEPTH_W-1:0] depth_i,
  output logic               rsp_vld_o,
  output logic               viol_o,
  output logic [LVL_W-1:0]   viol_lvl_o,
  output logic               hit_o,
  output logic               dirty_o,
  output logic               excl_o
);

  logic [DEPTH-1:0] sel_rw;
  line_st_t         sel_st;
  logic             found;
  logic [LVL_W-1:0] low_lvl;

  logic             vld_q, viol_q, hit_q, dirty_q, excl_q;
  logic             vld_d, viol_d, hit_d, dirty_d, excl_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  assign sel_rw = rw_all_i[snp_addr_i];
  assign sel_st = st_all_i[snp_addr_i];

  // outermost level holding the line
  always_comb begin
    found   = 1'b0;
    low_lvl = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (sel_rw[k]) begin
        found   = 1'b1;
        low_lvl = LVL_W'(k);
      end
    end
  end

  always_comb begin
    vld_d   = snp_i;
    viol_d  = snp_i & snp_inv_i & found;
    lvl_d   = (snp_i && snp_inv_i && found) ? low_lvl : '0;
    hit_d   = snp_i & sel_st.vld;
    dirty_d = snp_i & sel_st.dirty;
    excl_d  = snp_i & sel_st.excl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      viol_q  <= 1'b0;
      lvl_q   <= '0;
      hit_q   <= 1'b0;
      dirty_q <= 1'b0;
      excl_q  <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      viol_q  <= viol_d;
      lvl_q   <= lvl_d;
      hit_q   <= hit_d;
      dirty_q <= dirty_d;
      excl_q  <= excl_d;
    end
  end

  assign rsp_vld_o  = vld_q;
  assign viol_o     = viol_q;
  assign viol_lvl_o = lvl_q;
  assign hit_o      = hit_q;
  assign dirty_o    = dirty_q;
  assign excl_o     = excl_q;

  AST_VIOL_NEEDS_INV: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> $past(snp_i && snp_inv_i)); // R8
  AST_VIOL_LVL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> (DEPTH_W'(lvl_q) < $past(depth_i))); // R7
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(snp_i)); // R9

endmodule

// File: rtl/nested_rw_tracker.sv
module nested_rw_tracker
  import ntx_pkg::*;
#(
  parameter  int NUM_LINES = 16,
  parameter  int DEPTH     = 4,
  localparam int ADDR_W    = $clog2(NUM_LINES),
  localparam int LVL_W     = $clog2(DEPTH),
  localparam int DEPTH_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_begin_i,
  input  logic               tx_commit_i,
  input  logic               tx_abort_i,
  input  logic               ld_i,
  input  logic               st_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic               snp_i,
  input  logic               snp_inv_i,
  input  logic [ADDR_W-1:0]  snp_addr_i,
  output logic [DEPTH_W-1:0] depth_o,
  output logic               ovf_o,
  output logic               rsp_vld_o,
  output logic               viol_o,
  output logic [LVL_W-1:0]   viol_lvl_o,
  output logic               rsp_hit_o,
  output logic               rsp_dirty_o,
  output logic               rsp_excl_o
);

  logic [DEPTH_W-1:0] depth;
  logic [LVL_W-1:0]   cur_lvl;
  logic               in_txn;
  lvl_cmd_e           cmd;
  logic [DEPTH-1:0]   rw_all [NUM_LINES];
  line_st_t           st_all [NUM_LINES];

  ntx_depth_ctrl #(
    .DEPTH   (DEPTH),
    .DEPTH_W (DEPTH_W),
    .LVL_W   (LVL_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .begin_i   (tx_begin_i),
    .commit_i  (tx_commit_i),
    .abort_i   (tx_abort_i),
    .depth_o   (depth),
    .cur_lvl_o (cur_lvl),
    .in_txn_o  (in_txn),
    .cmd_o     (cmd),
    .ovf_o     (ovf_o)
  );

  for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
    logic acc_hit, snp_hit;
    assign acc_hit = (acc_addr_i == ADDR_W'(ln));
    assign snp_hit = snp_i && (snp_addr_i == ADDR_W'(ln));

    ntx_line #(
      .DEPTH   (DEPTH),
      .DEPTH_W (DEPTH_W),
      .LVL_W   (LVL_W)
    ) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_ld_i  (acc_hit & ld_i),
      .acc_st_i  (acc_hit & st_i),
      .in_txn_i  (in_txn),
      .cur_lvl_i (cur_lvl),
      .depth_i   (depth),
      .cmd_i     (cmd),
      .snp_sel_i (snp_hit),
      .snp_inv_i (snp_inv_i),
      .rw_o      (rw_all[ln]),
      .st_o      (st_all[ln])
    );
  end

  ntx_snoop_resp #(
    .NUM_LINES (NUM_LINES),
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .DEPTH_W   (DEPTH_W),
    .LVL_W     (LVL_W)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_i      (snp_i),
    .snp_inv_i  (snp_inv_i),
    .snp_addr_i (snp_addr_i),
    .rw_all_i   (rw_all),
    .st_all_i   (st_all),
    .depth_i    (depth),
    .rsp_vld_o  (rsp_vld_o),
    .viol_o     (viol_o),
    .viol_lvl_o (viol_lvl_o),
    .hit_o      (rsp_hit_o),
    .dirty_o    (rsp_dirty_o),
    .excl_o     (rsp_excl_o)
  );

  assign depth_o = depth;

endmodule

// File: tb/tb_nested_rw_tracker.sv
module tb_nested_rw_tracker;

  localparam int NL = 16;
  localparam int DP = 4;
  localparam int AW = $clog2(NL);
  localparam int LW = $clog2(DP);
  localparam int DW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_begin_i = 0, tx_commit_i = 0, tx_abort_i = 0;
  logic ld_i = 0, st_i = 0, snp_i = 0, snp_inv_i = 0;
  logic [AW-1:0] acc_addr_i = '0, snp_addr_i = '0;
  logic [DW-1:0] depth_o;
  logic ovf_o, rsp_vld_o, viol_o, rsp_hit_o, rsp_dirty_o, rsp_excl_o;
  logic [LW-1:0] viol_lvl_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  nested_rw_tracker #(.NUM_LINES(NL), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n),
    .tx_begin_i(tx_begin_i), .tx_commit_i(tx_commit_i), .tx_abort_i(tx_abort_i),
    .ld_i(ld_i), .st_i(st_i), .acc_addr_i(acc_addr_i),
    .snp_i(snp_i), .snp_inv_i(snp_inv_i), .snp_addr_i(snp_addr_i),
    .depth_o(depth_o), .ovf_o(ovf_o), .rsp_vld_o(rsp_vld_o), .viol_o(viol_o),
    .viol_lvl_o(viol_lvl_o), .rsp_hit_o(rsp_hit_o), .rsp_dirty_o(rsp_dirty_o),
    .rsp_excl_o(rsp_excl_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one-cycle operation: 0 begin, 1 commit, 2 abort, 3 load, 4 store
  task automatic op(input int kind, input int addr);
    @(negedge clk);
    tx_begin_i  = (kind == 0);
    tx_commit_i = (kind == 1);
    tx_abort_i  = (kind == 2);
    ld_i        = (kind == 3);
    st_i        = (kind == 4);
    acc_addr_i  = AW'(addr);
    @(negedge clk);
    tx_begin_i = 0; tx_commit_i = 0; tx_abort_i = 0; ld_i = 0; st_i = 0;
  endtask

  task automatic snoop(input string req, input int addr, input bit inv,
                       input int ev, input int el, input bit cst,
                       input int eh, input int ed, input int ee);
    @(negedge clk);
    snp_i = 1; snp_inv_i = inv; snp_addr_i = AW'(addr);
    @(negedge clk);
    snp_i = 0; snp_inv_i = 0;
    chk(req, "rsp_vld", int'(rsp_vld_o), 1);
    chk(req, "viol", int'(viol_o), ev);
    if (ev != 0) chk(req, "viol_lvl", int'(viol_lvl_o), el);
    if (cst) begin
      chk(req, "hit", int'(rsp_hit_o), eh);
      chk(req, "dirty", int'(rsp_dirty_o), ed);
      chk(req, "excl", int'(rsp_excl_o), ee);
    end
  endtask

  task automatic t_reset();
    chk("R1", "depth", int'(depth_o), 0);
    chk("R1", "ovf", int'(ovf_o), 0);
    chk("R1", "rsp_vld", int'(rsp_vld_o), 0);
    chk("R1", "viol", int'(viol_o), 0);
  endtask

  task automatic t_depth();
    op(1, 0);
    chk("R10", "depth after idle commit", int'(depth_o), 0);
    op(2, 0);
    chk("R10", "depth after idle abort", int'(depth_o), 0);
    for (int i = 1; i <= DP; i++) begin
      op(0, 0);
      chk("R2", "depth climb", int'(depth_o), i);
    end
    chk("R2", "ovf before refuse", int'(ovf_o), 0);
    op(0, 0);
    chk("R2", "depth refused", int'(depth_o), DP);
    chk("R2", "ovf set", int'(ovf_o), 1);
    op(3, 10);
    snoop("R3", 10, 1, 1, DP - 1, 0, 0, 0, 0);
    op(2, 0);
    chk("R2", "ovf held", int'(ovf_o), 1);
    for (int i = 0; i < DP - 1; i++) op(2, 0);
    chk("R5", "depth after aborts", int'(depth_o), 0);
    chk("R2", "ovf cleared", int'(ovf_o), 0);
    snoop("R5", 10, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_access();
    op(3, 1);
    snoop("R3", 1, 1, 0, 0, 1, 1, 0, 1);
    op(0, 0);
    op(3, 2);
    op(0, 0);
    op(4, 3);
    snoop("R8", 2, 0, 0, 0, 1, 1, 0, 1);
    snoop("R7", 2, 1, 1, 0, 1, 1, 0, 0);
    snoop("R8", 3, 0, 0, 0, 1, 1, 1, 1);
    snoop("R3", 3, 1, 1, 1, 1, 1, 1, 0);
    snoop("R8", 4, 1, 0, 0, 1, 0, 0, 0);
    op(1, 0);
    chk("R4", "depth after nested commit", int'(depth_o), 1);
    snoop("R4", 3, 1, 1, 0, 1, 0, 0, 0);
    op(1, 0);
    chk("R6", "depth after outer commit", int'(depth_o), 0);
    snoop("R6", 2, 1, 0, 0, 0, 0, 0, 0);
    snoop("R6", 3, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_abort();
    op(0, 0);
    op(3, 5);
    op(0, 0);
    op(3, 5);
    op(4, 6);
    op(0, 0);
    op(3, 7);
    snoop("R3", 7, 1, 1, 2, 0, 0, 0, 0);
    op(2, 0);
    chk("R5", "depth after abort", int'(depth_o), 2);
    snoop("R5", 7, 1, 0, 0, 0, 0, 0, 0);
    snoop("R5", 6, 1, 1, 1, 0, 0, 0, 0);
    op(2, 0);
    snoop("R5", 6, 1, 0, 0, 0, 0, 0, 0);
    snoop("R5", 5, 1, 1, 0, 0, 0, 0, 0);
    op(2, 0);
    chk("R5", "depth at end", int'(depth_o), 0);
    snoop("R5", 5, 1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_deep();
    op(0, 0);
    op(0, 0);
    op(0, 0);
    op(3, 8);
    op(4, 9);
    snoop("R3", 8, 1, 1, 2, 0, 0, 0, 0);
    op(1, 0);
    snoop("R4", 8, 1, 1, 1, 0, 0, 0, 0);
    op(1, 0);
    snoop("R4", 9, 1, 1, 0, 0, 0, 0, 0);
    op(1, 0);
    chk("R6", "depth", int'(depth_o), 0);
    snoop("R6", 8, 1, 0, 0, 0, 0, 0, 0);
    snoop("R6", 9, 1, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_depth();
    t_access();
    t_abort();
    t_deep();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule